// File: doc/BRIEF.md
# CAN Transmit Buffer Priority Selector

The block holds three outgoing CAN message buffers. Each buffer stores eight data bytes, a 4-bit length code and an 8-bit software priority. Each buffer also has an "empty" flag. The CPU fills a buffer through a simple register write port. It then requests transmission by writing a send command, which clears the buffer's empty flag and marks the buffer pending. While a buffer is pending, every write to it is refused, so its contents cannot change under the protocol engine.

The bit-level engine pulses a start-of-frame strobe when it is ready to send. At that strobe the block takes a snapshot of the pending buffers and picks one. The lowest priority number wins, and ties go to the lower buffer index. The block latches the winner. It then presents the winner's index, its clamped byte count and its data bytes, starting from byte 0, with the engine stepping through the bytes by pulses. A frame-done pulse from the engine marks the winner's buffer empty again and releases the selection.

Top module: `can_txbuf_sel`

## Requirements
- R1: After reset all three empty flags (`txe`) read 1 and `tx_valid` is 0.
- R2: A write of `wr_sel`=10 with `wr_data[0]`=1 to an empty buffer clears that buffer's empty flag (pending). The same write with `wr_data[0]`=0 has no effect.
- R3: Register writes (`wr_sel` 0–7 data byte, 8 length code in `wr_data[3:0]`, 9 priority, 10 send) to a buffer whose empty flag is 0 are ignored.
- R4: At a start-of-frame strobe with at least one pending buffer, the pending buffer with the numerically smallest priority is latched into `tx_idx`, and `tx_valid` rises on the next cycle.
- R5: When several pending buffers share the smallest priority, the lowest index among them wins.
- R6: Buffers that are not pending take no part in the selection, whatever their priority.
- R7: A start-of-frame strobe with no pending buffer leaves `tx_valid` at 0 and changes no state.
- R8: The selection is made only at the strobe. `tx_idx` holds until frame-done, even if a better buffer becomes pending, and a strobe while `tx_valid` is 1 is ignored.
- R9: A frame-done pulse while `tx_valid` is 1 sets the selected buffer's empty flag to 1 and drops `tx_valid` on the next cycle.
- R10: `tx_len` equals the selected buffer's length code, limited to 8 when the code is larger.
- R11: `tx_byte` starts at data byte 0 after the strobe. Each `byte_next` pulse advances it by one byte, and it stays at byte 7 once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_buf | input | 2 | Target buffer index |
| wr_sel | input | 4 | Register select: 0–7 data, 8 length, 9 priority, 10 send |
| wr_data | input | 8 | Write data |
| txe | output | 3 | Per-buffer empty flags (1 = empty) |
| sof | input | 1 | Start-of-frame strobe from the engine |
| byte_next | input | 1 | One-cycle request for the next data byte |
| frame_done | input | 1 | One-cycle pulse at the end of the frame |
| tx_valid | output | 1 | A buffer is latched for transmission |
| tx_idx | output | 2 | Latched buffer index |
| tx_len | output | 4 | Byte count of the latched buffer |
| tx_byte | output | 8 | Current data byte of the latched buffer |

## Verification
The bench goes after priority ties with small random priority values. A design that compared with less-or-equal would hand ties to the higher index. It also gives non-pending buffers low priority values, which a design that forgot the pending mask would pick. Writes aimed at pending buffers, followed by a later transmission of those buffers, expose any write-lock leak as corrupted bytes or a changed length. Strobes that arrive mid-frame or with nothing pending, length codes above 8, and byte stepping past the last segment check that the latch is not re-evaluated, that the count is clamped, and that the byte pointer saturates instead of wrapping.

// File: rtl/can_txbuf_sel.sv
module can_txbuf_sel #(
  parameter int NBUF  = 3,
  parameter int NBYTE = 8,
  parameter int DW    = 8,
  parameter int PW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NBUF)-1:0]     wr_buf,
  input  logic [$clog2(NBYTE+3)-1:0]  wr_sel,
  input  logic [DW-1:0]               wr_data,
  output logic [NBUF-1:0]             txe,
  input  logic                        sof,
  input  logic                        byte_next,
  input  logic                        frame_done,
  output logic                        tx_valid,
  output logic [$clog2(NBUF)-1:0]     tx_idx,
  output logic [$clog2(NBYTE+1)-1:0]  tx_len,
  output logic [DW-1:0]               tx_byte
);
  localparam int IW = $clog2(NBUF);
  localparam int BW = $clog2(NBYTE);
  localparam int LW = $clog2(NBYTE+1);

  logic [DW-1:0] data_q [NBUF][NBYTE];
  logic [LW-1:0] dlc_q  [NBUF];
  logic [PW-1:0] prio_q [NBUF];
  logic [NBUF-1:0] txe_q;
  logic [BW-1:0] ptr_q;
  logic [IW-1:0] win;
  logic [PW-1:0] best;
  logic          found;
  logic          wr_ok;

  assign wr_ok = wr_en && (int'(wr_buf) < NBUF) && txe_q[wr_buf];

  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '0;
    for (int i = 0; i < NBUF; i++)
      if (!txe_q[i] && (!found || prio_q[i] < best)) begin
        found = 1'b1;
        win   = IW'(i);
        best  = prio_q[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q    <= '1;
      tx_valid <= 1'b0;
      tx_idx   <= '0;
      ptr_q    <= '0;
      for (int b = 0; b < NBUF; b++) begin
        dlc_q[b]  <= '0;
        prio_q[b] <= '0;
        for (int k = 0; k < NBYTE; k++) data_q[b][k] <= '0;
      end
    end else begin
      if (wr_ok) begin
        if (int'(wr_sel) < NBYTE)       data_q[wr_buf][wr_sel[BW-1:0]] <= wr_data;
        else if (int'(wr_sel) == NBYTE)   dlc_q[wr_buf]  <= wr_data[LW-1:0];
        else if (int'(wr_sel) == NBYTE+1) prio_q[wr_buf] <= wr_data[PW-1:0];
        else if (int'(wr_sel) == NBYTE+2 && wr_data[0]) txe_q[wr_buf] <= 1'b0;
      end
      if (sof && !tx_valid && found) begin
        tx_valid <= 1'b1;
        tx_idx   <= win;
        ptr_q    <= '0;
      end
      if (tx_valid && byte_next && int'(ptr_q) != NBYTE-1) ptr_q <= ptr_q + 1'b1;
      if (tx_valid && frame_done) begin
        tx_valid      <= 1'b0;
        txe_q[tx_idx] <= 1'b1;
      end
    end
  end

  assign txe     = txe_q;
  assign tx_len  = (int'(dlc_q[tx_idx]) > NBYTE) ? LW'(NBYTE) : dlc_q[tx_idx];
  assign tx_byte = data_q[tx_idx][ptr_q];

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !frame_done |=> tx_valid && $stable(tx_idx));
  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && frame_done |=> !tx_valid && txe[$past(tx_idx)]);
  // R4
  sel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !txe[tx_idx]);
  // R7
  idle_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof && !tx_valid && (&txe) |=> !tx_valid);
  // R10
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_len) <= NBYTE);

  for (genvar g = 0; g < NBUF; g++) begin : g_lock
    // R3
    wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !txe[g] |=> $stable(prio_q[g]) && $stable(dlc_q[g]));
  end
endmodule

// File: tb/can_txbuf_sel_tb.sv
module can_txbuf_sel_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, sof = 0, byte_next = 0, frame_done = 0;
  logic [1:0] wr_buf = 0;
  logic [3:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] txe;
  logic tx_valid;
  logic [1:0] tx_idx;
  logic [3:0] tx_len;
  logic [7:0] tx_byte;

  always #5 clk = ~clk;

  can_txbuf_sel dut_i (.clk, .rst_n, .wr_en, .wr_buf, .wr_sel, .wr_data, .txe,
    .sof, .byte_next, .frame_done, .tx_valid, .tx_idx, .tx_len, .tx_byte);

  int checks = 0, errors = 0;
  logic [7:0] m_data [3][8];
  logic [3:0] m_dlc [3];
  logic [7:0] m_prio [3];
  logic [2:0] m_txe;
  logic m_valid;
  int m_idx, m_ptr;

  function automatic int pick();
    int w = -1;
    for (int i = 0; i < 3; i++)
      if (!m_txe[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
    return w;
  endfunction

  function automatic int clamp8(int v);
    return v > 8 ? 8 : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2/R3/R9 txe", txe, m_txe);
    chk("R7/R8/R9 tx_valid", tx_valid, m_valid);
    if (m_valid) begin
      chk("R4/R5/R6/R8 tx_idx", tx_idx, m_idx);
      chk("R10 tx_len", tx_len, clamp8(m_dlc[m_idx]));
      chk("R11 tx_byte", tx_byte, m_data[m_idx][m_ptr]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; sof = 0; byte_next = 0; frame_done = 0;
    check_all();
  endtask

  task automatic wr(int b, int s, int d);
    wr_en = 1; wr_buf = 2'(b); wr_sel = 4'(s); wr_data = 8'(d);
    if (b < 3 && m_txe[b]) begin
      if (s < 8) m_data[b][s] = 8'(d);
      else if (s == 8) m_dlc[b] = 4'(d);
      else if (s == 9) m_prio[b] = 8'(d);
      else if (s == 10 && d[0]) m_txe[b] = 0;
    end
    step();
  endtask

  task automatic do_sof();
    int w = pick();
    sof = 1;
    if (!m_valid && w >= 0) begin m_valid = 1; m_idx = w; m_ptr = 0; end
    step();
  endtask

  task automatic do_next();
    byte_next = 1;
    if (m_valid && m_ptr != 7) m_ptr++;
    step();
  endtask

  task automatic do_done();
    frame_done = 1;
    if (m_valid) begin m_valid = 0; m_txe[m_idx] = 1; end
    step();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h1234abcd;
    void'($urandom(seed));
    for (int b = 0; b < 3; b++) begin
      m_dlc[b] = 0; m_prio[b] = 0;
      for (int k = 0; k < 8; k++) m_data[b][k] = 0;
    end
    m_txe = 3'b111; m_valid = 0; m_idx = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txe", txe, 3'b111);
    chk("R1 tx_valid", tx_valid, 0);

    // R7 strobe with nothing pending
    do_sof();
    // fill buffers: priorities 5,2,2 (R5 tie), lengths incl. clamp (R10)
    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < 8; k++) wr(b, k, 16*b + k + 1);
      wr(b, 8, b == 2 ? 13 : 3 + b);
    end
    wr(0, 9, 5); wr(1, 9, 2); wr(2, 9, 2);
    wr(0, 10, 0);              // R2 bit0=0 ignored
    wr(0, 10, 1); wr(1, 10, 1); wr(2, 10, 1);
    wr(1, 9, 0); wr(1, 3, 8'hee); // R3 writes to pending ignored
    do_sof();                  // R5 expect index 1
    chk("R5 tie to lower index", tx_idx, 1);
    do_sof();                  // R8 ignored while valid
    for (int k = 0; k < 9; k++) do_next(); // R11 saturate at byte 7
    chk("R11 saturated byte", tx_byte, m_data[1][7]);
    do_done();                 // R9
    do_sof();                  // R5 buffer 2 next
    chk("R5 second tie winner", tx_idx, 2);
    chk("R10 clamp length 13", tx_len, 8);
    do_done();
    wr(2, 9, 0);               // R6 low prio, not pending
    do_sof();
    chk("R6 non-pending skipped", tx_idx, 0);
    wr(2, 10, 1);              // R8 better buffer arrives mid-frame
    do_next(); do_done();
    do_sof(); do_done();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) begin
        int s = $urandom_range(0, 10);
        int d = (s == 9) ? $urandom_range(0, 3) : $urandom_range(0, 255);
        wr($urandom_range(0, 2), s, d);
      end else if (op < 7) do_sof();
      else if (op < 9) do_next();
      else do_done();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule